// File: doc/BRIEF.md
# ADC Controller Register Interface

This block is the processor-facing register file of a four-channel analog-to-digital converter controller. It has an 8-bit register bus with an address, write data, a write strobe, a read strobe and combinational read data. Behind the bus sit three things. The first is a set of per-channel event flags that drive the interrupt request lines. The second is a one-byte holding register, so that a processor with an 8-bit bus can read a 16-bit conversion result atomically. The third is a 12-bit calibration word, split over two byte registers, that goes to the converter pipeline.

The converter side gives the block four inputs per channel: a conversion-done pulse, a compare-mode level, a compare-hit pulse and a vector-acknowledge pulse. It also supplies each channel's 16-bit result. Each flag has two possible set sources, and the channel's compare mode picks one of them. Each flag has two clear paths: the vector acknowledge and a write of one to the flag's bit. When a set and a clear for the same flag fall in the same cycle, the set wins, so no event is lost.

Software reads a result low byte first. That access returns the live low byte and, at the same clock edge, copies the live high byte into the holding register. A later read of the high-byte address returns the held copy, so both bytes come from the same sample.

Top module: `adc_regif`

## Requirements
- R1: With a channel's compare mode low, its flag (bit n of address 0x0, n = channel number) sets in the cycle after a conversion-done pulse, and a compare-hit pulse does not set it.
- R2: With a channel's compare mode high, its flag sets in the cycle after a compare-hit pulse, and a conversion-done pulse does not set it.
- R3: A vector-acknowledge pulse on a channel clears that channel's flag at the next edge and leaves the other flags unchanged.
- R4: A write to address 0x0 clears each flag whose bit is one in the write data. Flags whose bit is zero are unchanged.
- R5: If a set event and a clear (acknowledge or write-one) reach the same flag in the same cycle, the flag is set afterwards.
- R6: A read of address 0x4+2n returns bits 7:0 of channel n's live result and loads bits 15:8 into the holding register at that edge. A read of address 0x5+2n returns the holding register, even if the result has changed since.
- R7: The holding register at address 0x1 can be written and read back directly.
- R8: Address 0x2 holds calibration bits 7:0, and bits 3:0 of address 0x3 hold calibration bits 11:8. The 12-bit word appears on `cal_word` in the cycle after the write and does not change without a write to either address.
- R9: Bits 7:4 of addresses 0x0 and 0x3 always read zero, and writes to those bits are ignored.
- R10: Each `irq` bit is high exactly when that channel's flag is set and its `irq_en` bit is high.
- R11: After reset, all flags, the holding register and the calibration word are zero. `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| conv_done | input | 4 | Per-channel conversion-done pulse |
| cmp_mode | input | 4 | Per-channel compare-mode level |
| cmp_hit | input | 4 | Per-channel compare-hit pulse |
| vec_ack | input | 4 | Per-channel interrupt vector acknowledge pulse |
| res_flat | input | 64 | Four 16-bit results, channel n in bits 16n+15:16n |
| irq_en | input | 4 | Per-channel interrupt enable |
| irq | output | 4 | Per-channel interrupt request |
| cal_word | output | 12 | Calibration word |

## Verification
The bound checker covers these properties on every cycle:
- a selected set event always lands in the flag, and a flag never rises without one;
- an acknowledge without a set always clears its flag;
- a low-byte read always loads the matching high byte;
- the reserved flag bits always read zero;
- irq never rises above its enable;
- the calibration word holds still between writes.

Other behaviours need the bench's directed sweeps. These are the exact result of the write-one clear for every data byte, the full per-channel matrix of mode, hit, done and acknowledge with the flag set or clear beforehand, and whether the held high byte survives a change of the live result between the two reads. The sweeps also cover calibration readback with junk in the reserved bits, and the zero state after reset.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;
  localparam int unsigned NCH_DEF  = 4;
  localparam int unsigned DW_DEF   = 8;
  localparam int unsigned AW_DEF   = 4;
  localparam int unsigned CALW_DEF = 12;

  localparam logic [AW_DEF-1:0] A_FLAG = 4'h0;
  localparam logic [AW_DEF-1:0] A_HOLD = 4'h1;
  localparam logic [AW_DEF-1:0] A_CALL = 4'h2;
  localparam logic [AW_DEF-1:0] A_CALH = 4'h3;
  localparam logic [AW_DEF-1:0] A_RES0 = 4'h4;
endpackage

// File: rtl/adc_regif_rstsync.sv
module adc_regif_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/adc_regif_flags.sv
module adc_regif_flags #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] conv_done,
  input  logic [NCH-1:0] cmp_mode,
  input  logic [NCH-1:0] cmp_hit,
  input  logic [NCH-1:0] vec_ack,
  input  logic [NCH-1:0] wr_clr,
  output logic [NCH-1:0] flag_q
);
  logic [NCH-1:0] flag_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic set_ev;
    logic clr_ev;
    // compare mode picks which event sets the flag
    assign set_ev = cmp_mode[c] ? cmp_hit[c] : conv_done[c];
    assign clr_ev = vec_ack[c] | wr_clr[c];

    always_comb begin
      flag_d[c] = flag_q[c];
      if (clr_ev) flag_d[c] = 1'b0;
      if (set_ev) flag_d[c] = 1'b1;   // set has priority
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/adc_regif_snap.sv
module adc_regif_snap #(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 8,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*2*DW-1:0] res_flat,
  input  logic              lo_rd,
  input  logic [CW-1:0]     lo_ch,
  input  logic              hold_wr,
  input  logic [DW-1:0]     hold_wdata,
  output logic [DW-1:0]     hold_q
);
  logic [DW-1:0] hold_d;
  logic          hold_en;

  always_comb begin
    hold_en = lo_rd | hold_wr;
    hold_d  = hold_wdata;
    if (lo_rd) hold_d = res_flat[32'(lo_ch)*2*DW + DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end
endmodule

// File: rtl/adc_regif_cal.sv
module adc_regif_cal #(
  parameter int unsigned DW   = 8,
  parameter int unsigned CALW = 12,
  localparam int unsigned HIW = CALW - DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lo_wr,
  input  logic            hi_wr,
  input  logic [DW-1:0]   wdata,
  output logic [CALW-1:0] cal_q
);
  logic [DW-1:0]  lo_q;
  logic [HIW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_wr) lo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_wr) hi_q <= wdata[HIW-1:0];
  end

  assign cal_q = {hi_q, lo_q};
endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int unsigned NCH  = NCH_DEF,
  parameter int unsigned DW   = DW_DEF,
  parameter int unsigned AW   = AW_DEF,
  parameter int unsigned CALW = CALW_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NCH-1:0]      conv_done,
  input  logic [NCH-1:0]      cmp_mode,
  input  logic [NCH-1:0]      cmp_hit,
  input  logic [NCH-1:0]      vec_ack,
  input  logic [NCH*2*DW-1:0] res_flat,
  input  logic [NCH-1:0]      irq_en,
  output logic [NCH-1:0]      irq,
  output logic [CALW-1:0]     cal_word
);
  localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned HIW = CALW - DW;
  localparam logic [AW:0] RES_SPAN = (AW+1)'(2*NCH);

  logic           rst_q_n;
  logic [NCH-1:0] flag_q;
  logic [DW-1:0]  hold_q;
  logic [AW-1:0]  rel;
  logic           is_res;
  logic [CW-1:0]  res_ch;
  logic           lo_rd;
  logic [NCH-1:0] wr_clr;

  // address decode for the result window
  assign rel    = bus_addr - A_RES0;
  assign is_res = (bus_addr >= A_RES0) && ({1'b0, rel} < RES_SPAN);
  assign res_ch = rel[CW:1];
  assign lo_rd  = bus_rd && is_res && !rel[0];
  assign wr_clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[NCH-1:0] : '0;

  adc_regif_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  adc_regif_flags #(.NCH(NCH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .conv_done (conv_done),
    .cmp_mode  (cmp_mode),
    .cmp_hit   (cmp_hit),
    .vec_ack   (vec_ack),
    .wr_clr    (wr_clr),
    .flag_q    (flag_q)
  );

  adc_regif_snap #(.NCH(NCH), .DW(DW)) u_snap (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .res_flat   (res_flat),
    .lo_rd      (lo_rd),
    .lo_ch      (res_ch),
    .hold_wr    (bus_wr && bus_addr == A_HOLD),
    .hold_wdata (bus_wdata),
    .hold_q     (hold_q)
  );

  adc_regif_cal #(.DW(DW), .CALW(CALW)) u_cal (
    .clk   (clk),
    .rst_n (rst_q_n),
    .lo_wr (bus_wr && bus_addr == A_CALL),
    .hi_wr (bus_wr && bus_addr == A_CALH),
    .wdata (bus_wdata),
    .cal_q (cal_word)
  );

  assign irq = flag_q & irq_en;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_FLAG)      bus_rdata = DW'(flag_q);
      else if (bus_addr == A_HOLD) bus_rdata = hold_q;
      else if (bus_addr == A_CALL) bus_rdata = cal_word[DW-1:0];
      else if (bus_addr == A_CALH) bus_rdata = DW'(cal_word[CALW-1:CALW-HIW]);
      else if (is_res) begin
        if (rel[0]) bus_rdata = hold_q;
        else        bus_rdata = res_flat[32'(res_ch)*2*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int unsigned NCH  = 4,
  parameter int unsigned DW   = 8,
  parameter int unsigned AW   = 4,
  parameter int unsigned CALW = 12
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic [AW-1:0]       bus_addr,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [DW-1:0]       bus_rdata,
  input logic [NCH-1:0]      conv_done,
  input logic [NCH-1:0]      cmp_mode,
  input logic [NCH-1:0]      cmp_hit,
  input logic [NCH-1:0]      vec_ack,
  input logic [NCH*2*DW-1:0] res_flat,
  input logic [NCH-1:0]      irq_en,
  input logic [NCH-1:0]      irq,
  input logic [CALW-1:0]     cal_word,
  input logic [NCH-1:0]      flag_q,
  input logic [DW-1:0]       hold_q
);
  logic [NCH-1:0] ev;
  logic [NCH-1:0] ack_only;
  logic           rd_lo;
  logic [DW-1:0]  exp_hi;
  logic [AW-1:0]  off;

  assign ev       = (cmp_mode & cmp_hit) | (~cmp_mode & conv_done);
  assign ack_only = vec_ack & ~ev;
  assign off      = bus_addr - AW'(4);
  assign rd_lo    = bus_rd && !bus_wr && bus_addr >= AW'(4) && off < AW'(2*NCH) && !off[0];
  assign exp_hi   = res_flat[32'(off >> 1)*2*DW + DW +: DW];

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((flag_q & $past(ev)) == $past(ev)));                     // R1
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(ev)) == '0));          // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_only != '0) |=> ((flag_q & $past(ack_only)) == '0));          // R3
  AST_LO_READ_SNAPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_lo |=> (hold_q == $past(exp_hi)));                              // R6
  AST_CAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(bus_wr && (bus_addr == AW'(2) || bus_addr == AW'(3))) |=> $stable(cal_word)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_rd && (bus_addr == AW'(0) || bus_addr == AW'(3))) |-> (bus_rdata[DW-1:4] == '0)); // R9
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((irq & ~irq_en) == '0));                                          // R10
endmodule

bind adc_regif adc_regif_chk #(.NCH(NCH), .DW(DW), .AW(AW), .CALW(CALW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .conv_done (conv_done),
  .cmp_mode  (cmp_mode),
  .cmp_hit   (cmp_hit),
  .vec_ack   (vec_ack),
  .res_flat  (res_flat),
  .irq_en    (irq_en),
  .irq       (irq),
  .cal_word  (cal_word),
  .flag_q    (flag_q),
  .hold_q    (hold_q)
);

// File: tb/tb_adc_regif.sv
module tb_adc_regif;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_rdata;
  logic [3:0]  conv_done, cmp_mode, cmp_hit, vec_ack, irq_en, irq;
  logic [63:0] res_flat;
  logic [11:0] cal_word;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  adc_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .conv_done(conv_done), .cmp_mode(cmp_mode), .cmp_hit(cmp_hit),
    .vec_ack(vec_ack), .res_flat(res_flat), .irq_en(irq_en), .irq(irq),
    .cal_word(cal_word)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // entered at a falling edge, leaves at the next falling edge
  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_done(input logic [3:0] m);
    conv_done = m;
    @(negedge clk);
    conv_done = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    conv_done = '0; cmp_mode = '0; cmp_hit = '0; vec_ack = '0; irq_en = '0;
    res_flat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state and idle read data
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      check("R11 reset read", d, 0);
    end
    check("R11 cal after reset", cal_word, 0);
    irq_en = 4'hF; #1;
    check("R11 irq after reset", irq, 0);
    pulse_done(4'hF);
    bus_addr = 4'h0; #1;
    check("R11 rdata idle", bus_rdata, 0);
    wr(4'h0, 8'hFF);

    // R1 R2 R3 R5: every mode/hit/done/ack mix with flag low and high before
    for (int ch = 0; ch < 4; ch++)
      for (int pre = 0; pre < 2; pre++)
        for (int k = 0; k < 16; k++) begin
          logic m, h, dn, a, s, e;
          string tag;
          m = k[3]; h = k[2]; dn = k[1]; a = k[0];
          wr(4'h0, 8'hFF);
          if (pre != 0) pulse_done(4'(1 << ch));
          cmp_mode[ch] = m; cmp_hit[ch] = h; conv_done[ch] = dn; vec_ack[ch] = a;
          @(negedge clk);
          cmp_mode = '0; cmp_hit = '0; conv_done = '0; vec_ack = '0;
          s = m ? h : dn;
          e = s | ((pre != 0) & ~a);
          if (a && s)  tag = "R5 set beats ack";
          else if (a)  tag = "R3 ack clear";
          else if (m)  tag = "R2 compare set";
          else         tag = "R1 done set";
          rd(4'h0, d);
          check(tag, d, int'(e) << ch);
        end

    // R4 R9: write-one clear over every data byte
    for (int p = 0; p < 256; p++) begin
      pulse_done(4'hF);
      wr(4'h0, 8'(p));
      rd(4'h0, d);
      check("R4 R9 write-one clear", d, ~p & 4'hF);
    end

    // R5: write-one clear and conversion-done in one cycle
    wr(4'h0, 8'hFF);
    bus_addr = 4'h0; bus_wdata = 8'h0F; bus_wr = 1'b1; conv_done = 4'b0101;
    @(negedge clk);
    bus_wr = 1'b0; conv_done = '0;
    rd(4'h0, d);
    check("R5 set beats write clear", d, 8'h05);

    // R10: irq gating for every flag and enable pattern
    for (int f = 0; f < 16; f++)
      for (int en = 0; en < 16; en++) begin
        wr(4'h0, 8'hFF);
        pulse_done(4'(f));
        irq_en = 4'(en); #1;
        check("R10 irq gate", irq, f & en);
      end
    wr(4'h0, 8'hFF);

    // R6: consistent snapshot across a change of the live result
    for (int ch = 0; ch < 4; ch++) begin
      logic [15:0] v0, v1;
      v0 = 16'h1A2B + 16'(ch * 16'h3C4D);
      v1 = ~v0;
      res_flat[ch*16 +: 16] = v0;
      rd(4'(4 + 2*ch), d);
      check("R6 low byte live", d, v0[7:0]);
      res_flat[ch*16 +: 16] = v1;
      rd(4'(5 + 2*ch), d);
      check("R6 high byte held", d, v0[15:8]);
      rd(4'h1, d);
      check("R6 R7 hold visible", d, v0[15:8]);
    end

    // R7: direct write and readback of the holding register
    for (int v = 0; v < 256; v += 37) begin
      wr(4'h1, 8'(v));
      rd(4'h1, d);
      check("R7 hold readback", d, v);
    end

    // R8 R9: calibration words with junk in the reserved bits
    for (int v = 0; v < 4096; v += 293) begin
      wr(4'h2, 8'(v));
      wr(4'h3, 8'(8'hA0 | (v >> 8)));
      check("R8 cal word", cal_word, v);
      rd(4'h2, d);
      check("R8 cal low read", d, v & 8'hFF);
      rd(4'h3, d);
      check("R8 R9 cal high read", d, v >> 8);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule